// File: doc/BRIEF.md
# Configurable Frame Serial Transmitter

This block turns one parallel word into a serial frame on a single line, one bit per clock. A frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and then the line held high as the stop level. The data length, the parity setting and the stop-bit count are picked at run time by four small control inputs, which the block captures when it accepts a start request.

A five-state controller drives the line. A small loadable down-counter counts the data bits, so the controller does not need one state per bit. Between frames the line rests high and the ready flag is raised. The first idle cycle after a frame serves as the first stop bit, and an extra stop cycle is inserted only when two stop bits are selected. Baud-rate division, reception and buffering are left to neighbouring logic, and the caller paces the clock.

Top module: `frame_serial_tx`

## Requirements
- R1: While reset is asserted and after it is released with `go` low, `tx_line` is 1 and `ready` is 1, and they stay so until a start request arrives.
- R2: When `go` is 1 on a clock edge while `ready` is 1, then in the next cycle `tx_line` is 0 (start bit) and `ready` is 0.
- R3: The start bit is followed by 5 + `len_sel` data bits (`len_sel` 0..3 gives 5..8 bits), which are `data` bits 0, 1, 2 and so on in that order. `data` is sampled during the start-bit cycle.
- R4: With `par_en`=1, one parity bit follows the data bits. Its value is the XOR of the data bits sent, XORed with `par_odd`, so `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity.
- R5: With `par_en`=0, no parity bit is sent, and the cycle after the last data bit is a stop or idle cycle with `tx_line`=1.
- R6: With `two_stop`=1, one extra cycle with `tx_line`=1 and `ready`=0 follows the data or parity bits before the block returns to idle. With `two_stop`=0, the block returns straight to idle.
- R7: `ready` is 1 exactly in idle, and `tx_line` is 1 there. If `go` is held high, consecutive frames are separated by exactly one idle cycle.
- R8: `len_sel`, `two_stop`, `par_en` and `par_odd` are captured when a start request is accepted. Changing them later in the frame does not alter the frame. `data` may change once the start-bit cycle is over.
- R9: A `go` pulse that arrives while a frame is in progress is ignored, and the frame length does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, accepted only while ready |
| data | input | 8 | Word to send, sampled in the start-bit cycle |
| len_sel | input | 2 | Data length code, length = 5 + code |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | 1 appends a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_line | output | 1 | Serial output, high when idle |
| ready | output | 1 | High while idle and able to accept `go` |

## Verification
A bad counter load or decrement shows on the line within the same frame: the parity bit, the stop level or the next start bit appears one or more bit times early or late. The bench compares every cycle of the frame, so such an error is caught at the first misplaced bit. A wrong shift or parity preset shows up as a wrong data or parity value in the very cycle that bit is sent. A controller that leaves or skips idle wrongly shows as `ready` misbehaving in the cycle after the last bit.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_DAT  = 3'd2,
    ST_PAR  = 3'd3,
    ST_STOP = 3'd4
  } ftx_state_e;

  // Successor of the last data bit.
  function automatic ftx_state_e after_data(input logic par_en, input logic two_stop);
    if (par_en)   return ST_PAR;
    if (two_stop) return ST_STOP;
    return ST_IDLE;
  endfunction

  // Successor of the parity bit.
  function automatic ftx_state_e after_parity(input logic two_stop);
    return two_stop ? ST_STOP : ST_IDLE;
  endfunction

  // Counter preset: the count ends at zero after MIN_BITS+len_code cycles.
  function automatic int unsigned count_preset(input int unsigned min_bits,
                                               input int unsigned len_code);
    return min_bits - 1 + len_code;
  endfunction

endpackage

// File: rtl/ftx_bit_counter.sv
module ftx_bit_counter #(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [LEN_W-1:0] len_code,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  import ftx_pkg::*;

  logic [CNT_W-1:0] preset;
  assign preset = CNT_W'(count_preset(MIN_BITS, int'(len_code)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= preset;
    else if (dec)  count <= count - 1'b1;
  end

  assign last = (count == '0);
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  input  logic              par_init,
  output logic              lsb,
  output logic              parity
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      parity <= 1'b0;
    end else if (load) begin
      sr     <= din;
      parity <= par_init;
    end else if (shift) begin
      sr     <= {1'b0, sr[DATA_W-1:1]};
      parity <= parity ^ sr[0];
    end
  end

  assign lsb = sr[0];
endmodule

// File: rtl/ftx_ctrl.sv
module ftx_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               last,
  input  logic               par_en,
  input  logic               two_stop,
  output ftx_pkg::ftx_state_e state,
  output logic               go_take
);
  import ftx_pkg::*;

  ftx_state_e nxt;

  assign go_take = (state == ST_IDLE) && go;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (go) nxt = ST_INIT;
      ST_INIT: nxt = ST_DAT;
      ST_DAT:  if (last) nxt = after_data(par_en, two_stop);
      ST_PAR:  nxt = after_parity(two_stop);
      ST_STOP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              tx_line,
  output logic              ready
);
  import ftx_pkg::*;

  localparam int unsigned CNT_W = $clog2(DATA_W);

  ftx_state_e       state;
  logic             go_take;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic             sr_lsb;
  logic             par_bit;

  // Frame settings captured at acceptance.
  logic [LEN_W-1:0] cfg_len;
  logic             cfg_ns;
  logic             cfg_pe;
  logic             cfg_ps;

  // Named state events for the checker.
  logic st_idle, st_init, st_dat, st_par, st_stop;
  assign st_idle = (state == ST_IDLE);
  assign st_init = (state == ST_INIT);
  assign st_dat  = (state == ST_DAT);
  assign st_par  = (state == ST_PAR);
  assign st_stop = (state == ST_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_len <= '0;
      cfg_ns  <= 1'b0;
      cfg_pe  <= 1'b0;
      cfg_ps  <= 1'b0;
    end else if (go_take) begin
      cfg_len <= len_sel;
      cfg_ns  <= two_stop;
      cfg_pe  <= par_en;
      cfg_ps  <= par_odd;
    end
  end

  ftx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .last     (last),
    .par_en   (cfg_pe),
    .two_stop (cfg_ns),
    .state    (state),
    .go_take  (go_take)
  );

  ftx_bit_counter #(
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .MIN_BITS (MIN_BITS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_init),
    .dec      (st_dat),
    .len_code (cfg_len),
    .count    (cnt),
    .last     (last)
  );

  ftx_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_init),
    .shift    (st_dat),
    .din      (data),
    .par_init (cfg_ps),
    .lsb      (sr_lsb),
    .parity   (par_bit)
  );

  always_comb begin
    tx_line = 1'b1;
    if (st_init)     tx_line = 1'b0;
    else if (st_dat) tx_line = sr_lsb;
    else if (st_par) tx_line = par_bit;
  end

  assign ready = st_idle;
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned MIN_BITS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             tx_line,
  input logic             ready,
  input logic             st_init,
  input logic             st_dat,
  input logic             st_stop,
  input logic             last,
  input logic [CNT_W-1:0] cnt,
  input logic [LEN_W-1:0] cfg_len,
  input logic             cfg_ns,
  input logic             cfg_pe,
  input logic             cfg_ps
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> tx_line);

  assert_go_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && go) |=> (!tx_line && !ready));

  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_init |=> (cnt == CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_len)));

  assert_dat_continue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_dat && !last) |=> st_dat);

  assert_no_parity_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_dat && last && !cfg_pe && !cfg_ns) |=> ready);

  assert_stop_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_stop |=> (ready && tx_line));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !st_init) |-> $stable({cfg_len, cfg_ns, cfg_pe, cfg_ps}));
endmodule

bind frame_serial_tx ftx_checker u_ftx_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .tx_line (tx_line),
  .ready   (ready),
  .st_init (st_init),
  .st_dat  (st_dat),
  .st_stop (st_stop),
  .last    (last),
  .cnt     (cnt),
  .cfg_len (cfg_len),
  .cfg_ns  (cfg_ns),
  .cfg_pe  (cfg_pe),
  .cfg_ps  (cfg_ps)
);

// File: tb/test_frame_serial_tx.sv
`timescale 1ns/1ps
module test_frame_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] len_sel = '0;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       tx_line;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  frame_serial_tx i_frame_serial_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .data(data), .len_sel(len_sel),
    .two_stop(two_stop), .par_en(par_en), .par_odd(par_odd),
    .tx_line(tx_line), .ready(ready)
  );

  localparam logic [7:0] PAT [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                     8'h01, 8'h80, 8'h3C, 8'hE7};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ctrl = {len[1:0], two_stop, par_en, par_odd}
  task automatic run_frame(input logic [7:0] d, input logic [4:0] ctrl, input bit disturb);
    int n;
    logic par;
    n   = 5 + int'(ctrl[4:3]);
    par = ctrl[0];
    @(negedge clk);
    data = d; {len_sel, two_stop, par_en, par_odd} = ctrl; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R2 start bit", {tx_line, ready}, 8'b00);
    if (disturb) {len_sel, two_stop, par_en, par_odd} = ~ctrl;   // R8
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (disturb && i == 0) begin data = ~d; go = 1'b1; end       // R9
      if (disturb && i == 1) go = 1'b0;
      chk(disturb ? "R3 R8 data bit" : "R3 data bit", {tx_line, ready}, {d[i], 1'b0});
      par = par ^ d[i];
    end
    if (ctrl[1]) begin
      @(negedge clk);
      chk("R4 parity bit", {tx_line, ready}, {par, 1'b0});
    end
    if (ctrl[2]) begin
      @(negedge clk);
      chk("R6 second stop", {tx_line, ready}, 8'b10);
    end
    @(negedge clk);
    chk(disturb ? "R9 R5 R6 back to idle" : "R5 R6 R7 back to idle", {tx_line, ready}, 8'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1 in reset", {tx_line, ready}, 8'b11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {tx_line, ready}, 8'b11);

    // Table walk: all 32 control settings
    for (int i = 0; i < 32; i++)
      run_frame(PAT[i % 8] ^ 8'($urandom_range(255)), 5'(i), (i % 4) == 3);

    // R7: go held high gives exactly one idle cycle between frames
    @(negedge clk);
    data = 8'h96; {len_sel, two_stop, par_en, par_odd} = 5'b00000; go = 1'b1;
    @(negedge clk);
    chk("R7 first start", {tx_line, ready}, 8'b00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 data bit", {tx_line, ready}, {data[i], 1'b0});
    end
    @(negedge clk);
    chk("R7 single idle gap", {tx_line, ready}, 8'b11);
    @(negedge clk);
    go = 1'b0;
    chk("R7 next start", {tx_line, ready}, 8'b00);
    repeat (12) @(negedge clk);
    chk("R7 idle after drain", {tx_line, ready}, 8'b11);

    // R1: reset in the middle of a frame
    data = 8'h00; {len_sel, two_stop, par_en, par_odd} = 5'b11110; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-frame", {tx_line, ready}, 8'b11);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after mid reset", {tx_line, ready}, 8'b11);

    // Frame after reset still correct
    run_frame(8'hC3, 5'b11011, 1'b0);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule